// File: doc/BRIEF.md
# Round-Robin Interrupt Status Dispatcher

This block sits between a wide vector of raw interrupt status lines and a processor. A software-owned enable mask filters the status vector, and each source whose status and enable are both high counts as pending. When the processor pulses a dispatch request, the block picks one pending source and returns its number one cycle later. The search starts at a rotating pointer. After a grant, the pointer moves to one past the source that was served, so no source has fixed priority over another and every pending source is served in turn.

A contiguous window of status bits can be declared as cascaded external lines. A grant that falls inside that window is reported as an external line number, counted from the start of the window. The enable register can be addressed either by internal bit index or by external line number; the block translates the line number into the matching internal bit. A registered summary output tells the processor that something is pending. The source width is a power of two (32 or 64). The cascade window and its enable are elaboration-time parameters.

Top module: `rr_irq_dispatch`

## Requirements
- R1: A source is pending only when both its status bit and its enable bit are 1; a source with either bit at 0 is never granted.
- R2: A dispatch request made while nothing is pending returns disp_hit_o=0, disp_num_o=0 and disp_ext_o=0, and leaves the rotating pointer where it was.
- R3: The search for a grant starts at the rotating pointer and moves upward, wrapping modulo NSRC. After a grant, the pointer becomes the granted index plus one, modulo NSRC.
- R4: When several sources stay pending, successive dispatches serve them in ascending cyclic order, starting after the last one served, so no source is served twice before every other pending source has been served once.
- R5: With CASC_EN=1, a granted index in the window CASC_LO..CASC_HI (inclusive) is reported as disp_num_o = index - CASC_LO with disp_ext_o=1. Any other index is reported unchanged with disp_ext_o=0. With CASC_EN=0, disp_ext_o is always 0.
- R6: An enable write with mask_wr_set=1 sets one bit and with mask_wr_set=0 clears it. No other enable bit changes, and the register reads back on mask_rd_o from the cycle after the write.
- R7: With mask_wr_ext=1, mask_wr_idx is an external line number that targets internal enable bit CASC_LO + line. The write is ignored if the line is beyond the window or if CASC_EN=0.
- R8: irq_o is the OR of all pending bits, registered: it reflects status and enable as they were at the previous clock edge.
- R9: disp_ack_o is high for exactly the cycle after each cycle in which disp_req_i is high. disp_hit_o, disp_num_o and disp_ext_o change only on such a dispatch and hold between dispatches.
- R10: Synchronous active-high reset clears the enable register, the pointer, irq_o and all dispatch outputs.
- R11: With NSRC=64, the pointer wraps from 63 to 0, and index 63 is granted and reported in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_i | input | NSRC | Raw interrupt status vector |
| mask_wr_en | input | 1 | Enable-register bit write strobe |
| mask_wr_set | input | 1 | 1 sets the addressed bit, 0 clears it |
| mask_wr_ext | input | 1 | 1 means mask_wr_idx is an external line number |
| mask_wr_idx | input | IDXW | Bit index or external line number |
| mask_rd_o | output | NSRC | Enable register contents |
| disp_req_i | input | 1 | Dispatch request pulse |
| disp_ack_o | output | 1 | Dispatch result valid, one cycle after the request |
| disp_hit_o | output | 1 | A pending source was granted |
| disp_num_o | output | IDXW | Granted number (internal index or external line) |
| disp_ext_o | output | 1 | Granted number is an external line |
| irq_o | output | 1 | Registered summary of all pending sources |

## Verification
The bench goes after the pointer behaviour on an empty dispatch. A design that resets or advances the pointer there would serve a low-numbered source ahead of one just above the old pointer. The wrap from the top index back to zero is also exercised, on both widths; a pointer that is too narrow or that wraps at the wrong width would skip index 63 or repeat a source. The window edges (one below, first, last, one above) are targeted, because an off-by-one in the range test mislabels a line as internal or external. External-line enable writes, including one past the window, catch a design that shifts the wrong bit or lets a stray write through.

// File: rtl/rrd_pkg.sv
package rrd_pkg;

  // Direction of a single-bit enable-register write.
  typedef enum logic {
    MOP_CLR = 1'b0,
    MOP_SET = 1'b1
  } mask_op_e;

  // True when idx lies in the inclusive window [lo, hi].
  function automatic logic in_window(input int unsigned idx,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (idx >= lo) && (idx <= hi);
  endfunction

endpackage

// File: rtl/rrd_mask_reg.sv
module rrd_mask_reg #(
  parameter int NSRC    = 32,
  parameter int IDXW    = 5,
  parameter int CASC_EN = 1,
  parameter int CASC_LO = 8,
  parameter int CASC_HI = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_set,
  input  logic            wr_ext,
  input  logic [IDXW-1:0] wr_idx,
  output logic [NSRC-1:0] mask_q
);
  import rrd_pkg::*;

  localparam int unsigned EXT_N = CASC_HI - CASC_LO + 1;

  int unsigned     tgt;
  logic            tgt_ok;
  logic [NSRC-1:0] sel;
  mask_op_e        op;

  // Translate the request into an internal bit number and a legality flag.
  always_comb begin
    if (wr_ext) begin
      tgt    = CASC_LO + 32'(wr_idx);
      tgt_ok = (CASC_EN != 0) && (32'(wr_idx) < EXT_N);
    end else begin
      tgt    = 32'(wr_idx);
      tgt_ok = (32'(wr_idx) < NSRC);
    end
    op = mask_op_e'(wr_set);
  end

  // One-hot select for the addressed bit.
  for (genvar b = 0; b < NSRC; b++) begin : g_sel
    assign sel[b] = wr_en && tgt_ok && (tgt == 32'(b));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (|sel) begin
      if (op == MOP_SET) mask_q <= mask_q | sel;
      else               mask_q <= mask_q & ~sel;
    end
  end

endmodule

// File: rtl/rrd_rot_pick.sv
module rrd_rot_pick #(
  parameter int NSRC = 32,
  parameter int IDXW = 5
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [IDXW-1:0] ptr_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);

  logic [NSRC-1:0] rot;
  logic [IDXW-1:0] off;

  // rot[g] holds the source g places above the pointer (wrapping).
  for (genvar g = 0; g < NSRC; g++) begin : g_rot
    logic [IDXW-1:0] pos;
    assign pos    = ptr_i + IDXW'(g);
    assign rot[g] = pend_i[pos];
  end

  // Lowest set bit of the rotated vector is the nearest source at or above the pointer.
  always_comb begin
    off = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (rot[k]) off = IDXW'(k);
    end
  end

  assign any_o = |pend_i;
  assign idx_o = ptr_i + off;

endmodule

// File: rtl/rrd_remap.sv
module rrd_remap #(
  parameter int NSRC    = 32,
  parameter int IDXW    = 5,
  parameter int CASC_EN = 1,
  parameter int CASC_LO = 8,
  parameter int CASC_HI = 11
) (
  input  logic [IDXW-1:0] idx_i,
  output logic [IDXW-1:0] num_o,
  output logic            ext_o
);
  import rrd_pkg::*;

  if (CASC_EN != 0 && CASC_HI < NSRC) begin : g_casc
    logic win;
    always_comb begin
      win   = in_window(32'(idx_i), CASC_LO, CASC_HI);
      ext_o = win;
      num_o = win ? IDXW'(32'(idx_i) - CASC_LO) : idx_i;
    end
  end else begin : g_flat
    assign ext_o = 1'b0;
    assign num_o = idx_i;
  end

endmodule

// File: rtl/rr_irq_dispatch.sv
module rr_irq_dispatch #(
  parameter int NSRC    = 32,
  parameter int CASC_EN = 1,
  parameter int CASC_LO = 8,
  parameter int CASC_HI = 11,
  localparam int IDXW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] status_i,
  input  logic            mask_wr_en,
  input  logic            mask_wr_set,
  input  logic            mask_wr_ext,
  input  logic [IDXW-1:0] mask_wr_idx,
  output logic [NSRC-1:0] mask_rd_o,
  input  logic            disp_req_i,
  output logic            disp_ack_o,
  output logic            disp_hit_o,
  output logic [IDXW-1:0] disp_num_o,
  output logic            disp_ext_o,
  output logic            irq_o
);

  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend;
  logic [IDXW-1:0] ptr_q;
  logic            any;
  logic [IDXW-1:0] pick_idx;
  logic [IDXW-1:0] map_num;
  logic            map_ext;

  rrd_mask_reg #(
    .NSRC(NSRC), .IDXW(IDXW), .CASC_EN(CASC_EN),
    .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)
  ) u_mask (
    .clk   (clk),
    .rst   (rst),
    .wr_en (mask_wr_en),
    .wr_set(mask_wr_set),
    .wr_ext(mask_wr_ext),
    .wr_idx(mask_wr_idx),
    .mask_q(mask_q)
  );

  assign pend = status_i & mask_q;

  rrd_rot_pick #(.NSRC(NSRC), .IDXW(IDXW)) u_pick (
    .pend_i(pend),
    .ptr_i (ptr_q),
    .any_o (any),
    .idx_o (pick_idx)
  );

  rrd_remap #(
    .NSRC(NSRC), .IDXW(IDXW), .CASC_EN(CASC_EN),
    .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)
  ) u_remap (
    .idx_i(pick_idx),
    .num_o(map_num),
    .ext_o(map_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q      <= '0;
      disp_ack_o <= 1'b0;
      disp_hit_o <= 1'b0;
      disp_num_o <= '0;
      disp_ext_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      irq_o      <= any;
      disp_ack_o <= disp_req_i;
      if (disp_req_i) begin
        disp_hit_o <= any;
        disp_num_o <= any ? map_num : '0;
        disp_ext_o <= any & map_ext;
        if (any) ptr_q <= pick_idx + IDXW'(1);
      end
    end
  end

  assign mask_rd_o = mask_q;

endmodule

// File: rtl/rrd_checker.sv
module rrd_checker #(
  parameter int NSRC    = 32,
  parameter int IDXW    = 5,
  parameter int CASC_EN = 1,
  parameter int CASC_LO = 8,
  parameter int CASC_HI = 11
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] status_i,
  input logic [NSRC-1:0] mask_rd_o,
  input logic            mask_wr_en,
  input logic            disp_req_i,
  input logic            disp_ack_o,
  input logic            disp_hit_o,
  input logic [IDXW-1:0] disp_num_o,
  input logic            disp_ext_o,
  input logic            irq_o,
  input logic [IDXW-1:0] ptr_q
);
  localparam int unsigned EXT_N = CASC_HI - CASC_LO + 1;

  assert_ack_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
    disp_req_i |=> disp_ack_o);

  assert_no_spurious_ack_R9: assert property (@(posedge clk) disable iff (rst)
    !disp_req_i |=> !disp_ack_o);

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (rst)
    !disp_req_i |=> ($stable(disp_num_o) && $stable(disp_hit_o) && $stable(disp_ext_o)));

  assert_empty_no_hit_R2: assert property (@(posedge clk) disable iff (rst)
    (disp_req_i && (status_i & mask_rd_o) == '0) |=> (!disp_hit_o && $stable(ptr_q)));

  assert_pending_hit_R1: assert property (@(posedge clk) disable iff (rst)
    (disp_req_i && (status_i & mask_rd_o) != '0) |=> disp_hit_o);

  assert_ext_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    disp_ext_o |-> (CASC_EN != 0 && 32'(disp_num_o) < EXT_N));

  assert_mask_one_bit_R6: assert property (@(posedge clk) disable iff (rst)
    mask_wr_en |=> ($countones(mask_rd_o ^ $past(mask_rd_o)) <= 1));

  assert_mask_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !mask_wr_en |=> $stable(mask_rd_o));

  assert_irq_summary_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == (|$past(status_i & mask_rd_o))));

endmodule

bind rr_irq_dispatch rrd_checker #(
  .NSRC(NSRC), .IDXW(IDXW), .CASC_EN(CASC_EN),
  .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .status_i  (status_i),
  .mask_rd_o (mask_rd_o),
  .mask_wr_en(mask_wr_en),
  .disp_req_i(disp_req_i),
  .disp_ack_o(disp_ack_o),
  .disp_hit_o(disp_hit_o),
  .disp_num_o(disp_num_o),
  .disp_ext_o(disp_ext_o),
  .irq_o     (irq_o),
  .ptr_q     (ptr_q)
);

// File: tb/rr_irq_dispatch_tb.sv
`timescale 1ns/1ps
module rr_irq_dispatch_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;

  // ---------------- 32-source instance, cascade window 8..11
  logic [31:0] st32 = '0;
  logic        we32 = 0, ws32 = 0, wx32 = 0, rq32 = 0;
  logic [4:0]  wi32 = '0;
  logic [31:0] mrd32;
  logic        ack32, hit32, ext32, irq32;
  logic [4:0]  num32;

  rr_irq_dispatch #(.NSRC(32), .CASC_EN(1), .CASC_LO(8), .CASC_HI(11)) dut_i (
    .clk(clk), .rst(rst), .status_i(st32),
    .mask_wr_en(we32), .mask_wr_set(ws32), .mask_wr_ext(wx32), .mask_wr_idx(wi32),
    .mask_rd_o(mrd32), .disp_req_i(rq32), .disp_ack_o(ack32), .disp_hit_o(hit32),
    .disp_num_o(num32), .disp_ext_o(ext32), .irq_o(irq32));

  // ---------------- 64-source instance, no cascade
  logic [63:0] st64 = '0;
  logic        we64 = 0, ws64 = 0, rq64 = 0;
  logic [5:0]  wi64 = '0;
  logic [63:0] mrd64;
  logic        ack64, hit64, ext64, irq64;
  logic [5:0]  num64;

  rr_irq_dispatch #(.NSRC(64), .CASC_EN(0), .CASC_LO(0), .CASC_HI(0)) dut64_i (
    .clk(clk), .rst(rst), .status_i(st64),
    .mask_wr_en(we64), .mask_wr_set(ws64), .mask_wr_ext(1'b0), .mask_wr_idx(wi64),
    .mask_rd_o(mrd64), .disp_req_i(rq64), .disp_ack_o(ack64), .disp_hit_o(hit64),
    .disp_num_o(num64), .disp_ext_o(ext64), .irq_o(irq64));

  // Bench model of the 32-source instance
  logic [31:0] m32  = '0;
  int          ptr32 = 0;

  task automatic check(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic mw32(input logic set, input logic ext, input int idx);
    @(negedge clk);
    we32 = 1; ws32 = set; wx32 = ext; wi32 = 5'(idx);
    @(negedge clk);
    we32 = 0;
    if (!ext) m32[idx] = set;
    else if (idx < 4) m32[8 + idx] = set;
  endtask

  task automatic disp32(input string rq);
    int exp_idx = -1;
    logic [31:0] p = st32 & m32;
    for (int k = 0; k < 32; k++) begin
      if (exp_idx < 0 && p[(ptr32 + k) % 32]) exp_idx = (ptr32 + k) % 32;
    end
    @(negedge clk);
    rq32 = 1;
    @(negedge clk);
    rq32 = 0;
    check(rq, "ack", ack32, 1);
    if (exp_idx < 0) begin
      check(rq, "hit", hit32, 0);
      check(rq, "num", num32, 0);
      check(rq, "ext", ext32, 0);
    end else begin
      check(rq, "hit", hit32, 1);
      if (exp_idx >= 8 && exp_idx <= 11) begin
        check(rq, "num", num32, 64'(exp_idx - 8));
        check(rq, "ext", ext32, 1);
      end else begin
        check(rq, "num", num32, 64'(exp_idx));
        check(rq, "ext", ext32, 0);
      end
      ptr32 = (exp_idx + 1) % 32;
    end
  endtask

  task automatic clear_all32();
    for (int b = 0; b < 32; b++) if (m32[b]) mw32(0, 0, b);
  endtask

  task automatic t_reset();
    check("R10", "mask", mrd32, 0);
    check("R10", "irq",  irq32, 0);
    check("R10", "hit",  hit32, 0);
    check("R10", "ack",  ack32, 0);
    check("R10", "num",  num32, 0);
    check("R10", "mask64", mrd64, 0);
  endtask

  task automatic t_mask_bits();
    mw32(1, 0, 0); mw32(1, 0, 7); mw32(1, 0, 31);
    check("R6", "mask after sets", mrd32, 32'h8000_0081);
    mw32(0, 0, 7);
    check("R6", "mask after clear 7", mrd32, 32'h8000_0001);
    mw32(0, 0, 0); mw32(0, 0, 31);
    check("R6", "mask cleared", mrd32, 0);
  endtask

  task automatic t_ext_mask();
    mw32(1, 1, 2);
    check("R7", "ext line 2 -> bit 10", mrd32, 32'h0000_0400);
    mw32(1, 1, 5);
    check("R7", "ext line 5 ignored", mrd32, 32'h0000_0400);
    mw32(1, 1, 3);
    check("R7", "ext line 3 -> bit 11", mrd32, 32'h0000_0C00);
    mw32(0, 1, 2);
    check("R7", "ext clear line 2", mrd32, 32'h0000_0800);
    mw32(0, 1, 3);
    check("R7", "ext clear line 3", mrd32, 0);
  endtask

  task automatic t_irq();
    st32 = '0;
    mw32(1, 0, 4);
    @(negedge clk);
    check("R8", "irq no status", irq32, 0);
    st32[4] = 1'b1;
    #0.1;
    check("R8", "irq before edge", irq32, 0);
    @(negedge clk);
    check("R8", "irq after edge", irq32, 1);
    mw32(0, 0, 4);
    @(negedge clk);
    check("R8", "irq after mask clear", irq32, 0);
    st32 = '0;
  endtask

  task automatic t_masked_source();
    st32 = '0;
    st32[6] = 1'b1;
    mw32(1, 0, 5);
    disp32("R1");
    check("R1", "status-only/mask-only not granted", hit32, 0);
    st32[5] = 1'b1;
    disp32("R1");
    check("R1", "granted 5", num32, 5);
    clear_all32();
  endtask

  task automatic t_empty_keeps_ptr();
    st32 = '1;
    disp32("R2");
    mw32(1, 0, 19);
    disp32("R3");
    mw32(0, 0, 19);
    disp32("R2");
    mw32(1, 0, 3); mw32(1, 0, 25);
    disp32("R2");
    check("R2", "pointer kept after empty dispatch", num32, 25);
    clear_all32();
  endtask

  task automatic t_rotate();
    st32 = '1;
    mw32(1, 0, 2); mw32(1, 0, 9); mw32(1, 0, 30);
    for (int i = 0; i < 6; i++) disp32("R4");
    clear_all32();
  endtask

  task automatic t_window_edges();
    int ext_seen = 0;
    st32 = '1;
    mw32(1, 0, 7); mw32(1, 0, 8); mw32(1, 0, 11); mw32(1, 0, 12);
    for (int i = 0; i < 4; i++) begin
      disp32("R5");
      if (ext32) ext_seen++;
    end
    check("R5", "external grants in 4 dispatches", 64'(ext_seen), 2);
    clear_all32();
  endtask

  task automatic t_ack_hold();
    logic [4:0] n0;
    st32 = '1;
    mw32(1, 0, 14);
    disp32("R9");
    n0 = num32;
    @(negedge clk);
    check("R9", "ack drops", ack32, 0);
    mw32(1, 0, 15);
    @(negedge clk);
    check("R9", "num holds", num32, 64'(n0));
    check("R9", "hit holds", hit32, 1);
    clear_all32();
  endtask

  task automatic mw64(input logic set, input int idx);
    @(negedge clk);
    we64 = 1; ws64 = set; wi64 = 6'(idx);
    @(negedge clk);
    we64 = 0;
  endtask

  task automatic disp64();
    @(negedge clk);
    rq64 = 1;
    @(negedge clk);
    rq64 = 0;
  endtask

  task automatic t_wrap64();
    st64 = '1;
    mw64(1, 1); mw64(1, 63); mw64(1, 40);
    disp64(); check("R11", "first grant", num64, 1);
    disp64(); check("R11", "second grant", num64, 40);
    disp64(); check("R11", "index 63", num64, 63);
    check("R11", "no ext when cascade off", ext64, 0);
    disp64(); check("R11", "wrap to 1", num64, 1);
    disp64(); check("R11", "rotate to 40", num64, 40);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_mask_bits();
    t_ext_mask();
    t_irq();
    t_masked_source();
    t_empty_keeps_ptr();
    t_rotate();
    t_window_edges();
    t_ack_hold();
    t_wrap64();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule